// File: doc/BRIEF.md
# Two-Stage Integer Execute Unit

This block is the integer execute section of an in-order pipeline. Each cycle it accepts one decoded instruction: an opcode class, two 32-bit register operands already read from the register file, a signed literal, a destination tag and a valid bit. The work is split across two one-cycle stages. The first stage chooses the operands and the function. The second stage runs the adder, multiplier or logic unit and registers the outcome. The result, or the memory address for a load or store, appears at the second-stage output together with its tag and a zero indication. The writeback stage uses the zero indication later.

A constant move uses no separate path. It goes through the adder as the literal plus zero. Both memory address forms also share the adder: register plus literal, and register plus register. The decoder places the two address registers on the two operand inputs. A synchronous flush input discards everything in flight, so a taken branch further down the pipeline can squash younger work in a single cycle.

Top module: `xu_exec2`

## Requirements
- R1: While reset is held, and after it is released with no input, `out_valid`, `out_value`, `out_tag`, `out_zero` and `out_is_addr` are all zero.
- R2: A legal instruction sampled with `in_valid` high at a clock edge, with no flush at that edge or the next, appears on the outputs right after the second edge, carrying its tag. Back-to-back instructions come out one per cycle in order.
- R3: Register forms on operands a and b, with results taken modulo 2^32: opcode 0 gives a+b, opcode 1 gives a-b, opcode 2 gives the low 32 bits of a*b, opcode 3 gives a AND b, opcode 4 gives a OR b, opcode 5 gives a XOR b.
- R4: Literal forms: opcode 6 gives a+lit and opcode 7 gives a-lit. Opcode 8 (constant move) gives lit+0, and a and b have no effect on it.
- R5: Address forms set `out_is_addr`: opcode 9 gives a+lit and opcode 10 gives a+b. For every other opcode `out_is_addr` is 0.
- R6: `out_zero` is 1 exactly when a valid result from opcodes 0, 1, 2, 6 or 7 equals zero. It is 0 for the logic forms, the constant move and the address forms, whatever their value.
- R7: An input with `in_valid` low, or with an opcode from 11 to 15, yields a bubble two edges later: `out_valid` is 0 and all other outputs are 0.
- R8: `flush` high at a clock edge drops the instruction in each stage and the instruction sampled at that edge. Outputs are a bubble after that edge and the next one. An instruction presented in the cycle after the flush is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all in-flight and incoming work |
| in_valid | input | 1 | Instruction present on the inputs |
| in_op | input | 4 | Opcode class (encodings in R3 to R5) |
| in_a | input | 32 | First register operand |
| in_b | input | 32 | Second register operand |
| in_lit | input | 32 | Sign-extended literal |
| in_tag | input | 4 | Destination register tag |
| out_valid | output | 1 | Result present at the EX2 output |
| out_value | output | 32 | Result or memory address |
| out_tag | output | 4 | Destination tag of the result |
| out_zero | output | 1 | Arithmetic result equals zero |
| out_is_addr | output | 1 | `out_value` is a memory address |

## Verification
The hardest case to reach from the ports is a flush that lands while both stages hold live instructions and a third is waiting on the inputs, because every one of them must vanish while the instruction one cycle behind survives. The directed part builds this on purpose: it fills the pipe back to back, raises flush for one cycle, then issues again at once. A long random run then raises flush at irregular points. It also mixes in bubbles, illegal opcodes and operand pairs chosen to give a zero result, so flushes meet every occupancy pattern.

// File: rtl/xu_pkg.sv
package xu_pkg;

    typedef enum logic [3:0] {
        OPC_ADD   = 4'd0,
        OPC_SUB   = 4'd1,
        OPC_MUL   = 4'd2,
        OPC_AND   = 4'd3,
        OPC_OR    = 4'd4,
        OPC_XOR   = 4'd5,
        OPC_ADDI  = 4'd6,
        OPC_SUBI  = 4'd7,
        OPC_MOVK  = 4'd8,
        OPC_AGENI = 4'd9,
        OPC_AGENR = 4'd10
    } xu_opc_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_MUL = 3'd2,
        FN_AND = 3'd3,
        FN_OR  = 3'd4,
        FN_XOR = 3'd5
    } xu_fn_e;

endpackage

// File: rtl/xu_opnd_sel.sv
module xu_opnd_sel
    import xu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] lit,
    output logic [DW-1:0] x,
    output logic [DW-1:0] y,
    output xu_fn_e        fn,
    output logic          legal,
    output logic          set_z,
    output logic          is_addr
);

    always_comb begin
        x       = a;
        y       = b;
        fn      = FN_ADD;
        legal   = 1'b1;
        set_z   = 1'b0;
        is_addr = 1'b0;
        case (xu_opc_e'(op))
            OPC_ADD:   begin fn = FN_ADD; set_z = 1'b1; end
            OPC_SUB:   begin fn = FN_SUB; set_z = 1'b1; end
            OPC_MUL:   begin fn = FN_MUL; set_z = 1'b1; end
            OPC_AND:   fn = FN_AND;
            OPC_OR:    fn = FN_OR;
            OPC_XOR:   fn = FN_XOR;
            OPC_ADDI:  begin y = lit; fn = FN_ADD; set_z = 1'b1; end
            OPC_SUBI:  begin y = lit; fn = FN_SUB; set_z = 1'b1; end
            OPC_MOVK:  begin x = lit; y = '0; fn = FN_ADD; end
            OPC_AGENI: begin y = lit; fn = FN_ADD; is_addr = 1'b1; end
            OPC_AGENR: begin fn = FN_ADD; is_addr = 1'b1; end
            default:   legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/xu_alu.sv
module xu_alu
    import xu_pkg::*;
#(
    parameter int DW = 32
) (
    input  xu_fn_e        fn,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] res,
    output logic          is_zero
);

    logic [DW-1:0] sum;
    logic [DW-1:0] prod;

    // one adder serves add and subtract through operand inversion
    logic          do_sub;
    assign do_sub = (fn == FN_SUB);
    assign sum    = x + (do_sub ? ~y : y) + {{(DW-1){1'b0}}, do_sub};
    assign prod   = x * y;

    always_comb begin
        case (fn)
            FN_ADD:  res = sum;
            FN_SUB:  res = sum;
            FN_MUL:  res = prod;
            FN_AND:  res = x & y;
            FN_OR:   res = x | y;
            FN_XOR:  res = x ^ y;
            default: res = '0;
        endcase
    end

    assign is_zero = (res == '0);

endmodule

// File: rtl/xu_exec2.sv
module xu_exec2
    import xu_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [DW-1:0] in_lit,
    input  logic [TW-1:0] in_tag,
    output logic          out_valid,
    output logic [DW-1:0] out_value,
    output logic [TW-1:0] out_tag,
    output logic          out_zero,
    output logic          out_is_addr
);

    typedef struct packed {
        logic          valid;
        xu_fn_e        fn;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [TW-1:0] tag;
        logic          set_z;
        logic          is_addr;
    } ex1_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] value;
        logic [TW-1:0] tag;
        logic          zero;
        logic          is_addr;
    } ex2_t;

    ex1_t ex1_d, ex1_q;
    ex2_t ex2_d, ex2_q;

    logic [DW-1:0] sel_x, sel_y;
    xu_fn_e        sel_fn;
    logic          sel_legal, sel_set_z, sel_is_addr;
    logic [DW-1:0] alu_res;
    logic          alu_zero;

    xu_opnd_sel #(.DW(DW)) u_sel (
        .op      (in_op),
        .a       (in_a),
        .b       (in_b),
        .lit     (in_lit),
        .x       (sel_x),
        .y       (sel_y),
        .fn      (sel_fn),
        .legal   (sel_legal),
        .set_z   (sel_set_z),
        .is_addr (sel_is_addr)
    );

    xu_alu #(.DW(DW)) u_alu (
        .fn      (ex1_q.fn),
        .x       (ex1_q.x),
        .y       (ex1_q.y),
        .res     (alu_res),
        .is_zero (alu_zero)
    );

    always_comb begin
        ex1_d = '0;
        if (!flush && in_valid && sel_legal) begin
            ex1_d.valid   = 1'b1;
            ex1_d.fn      = sel_fn;
            ex1_d.x       = sel_x;
            ex1_d.y       = sel_y;
            ex1_d.tag     = in_tag;
            ex1_d.set_z   = sel_set_z;
            ex1_d.is_addr = sel_is_addr;
        end

        ex2_d = '0;
        if (!flush && ex1_q.valid) begin
            ex2_d.valid   = 1'b1;
            ex2_d.value   = alu_res;
            ex2_d.tag     = ex1_q.tag;
            ex2_d.zero    = ex1_q.set_z & alu_zero;
            ex2_d.is_addr = ex1_q.is_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex1_q <= '0;
            ex2_q <= '0;
        end else begin
            ex1_q <= ex1_d;
            ex2_q <= ex2_d;
        end
    end

    assign out_valid   = ex2_q.valid;
    assign out_value   = ex2_q.value;
    assign out_tag     = ex2_q.tag;
    assign out_zero    = ex2_q.zero;
    assign out_is_addr = ex2_q.is_addr;

    // R2: accepted instruction enters EX1, then moves to EX2 with its tag
    a_r2_enter_ex1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_legal && !flush) |=> ex1_q.valid);
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (ex1_q.valid && !flush) |=> (out_valid && out_tag == $past(ex1_q.tag)));

    // R7: illegal opcodes and bubbles never occupy a stage
    a_r7_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !sel_legal) |=> !ex1_q.valid);
    a_r7_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_value == '0 && out_tag == '0 && !out_zero && !out_is_addr));

    // R8: flush empties both stages at the next edge
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!ex1_q.valid && !out_valid));

    // R6: zero indication only with a zero value, never on an address
    a_r6_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
        out_zero |-> (out_valid && out_value == '0 && !out_is_addr));

endmodule

// File: tb/tb_xu_exec2.sv
`timescale 1ns/1ps
module tb_xu_exec2;

    localparam int CYC = 10;

    logic        clk = 1'b0;
    logic        rst_n, flush, in_valid;
    logic [3:0]  in_op, in_tag;
    logic [31:0] in_a, in_b, in_lit;
    logic        out_valid, out_zero, out_is_addr;
    logic [31:0] out_value;
    logic [3:0]  out_tag;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CYC/2) clk = ~clk;

    xu_exec2 dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_lit(in_lit), .in_tag(in_tag),
        .out_valid(out_valid), .out_value(out_value), .out_tag(out_tag),
        .out_zero(out_zero), .out_is_addr(out_is_addr)
    );

    typedef struct {
        logic        v;
        logic [31:0] val;
        logic [3:0]  tag;
        logic        z;
        logic        ad;
        string       req;
    } exp_t;

    exp_t pipe[$];

    function automatic exp_t bubble(string r);
        exp_t e;
        e.v = 0; e.val = 0; e.tag = 0; e.z = 0; e.ad = 0; e.req = r;
        return e;
    endfunction

    function automatic exp_t ref_calc(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                      logic [31:0] lit, logic [3:0] tag);
        exp_t e;
        logic arith;
        e = bubble("R7");
        arith = 0;
        e.v = 1; e.tag = tag;
        case (op)
            4'd0:  begin e.val = a + b;  arith = 1; e.req = "R3"; end
            4'd1:  begin e.val = a - b;  arith = 1; e.req = "R3"; end
            4'd2:  begin e.val = a * b;  arith = 1; e.req = "R3"; end
            4'd3:  begin e.val = a & b;  e.req = "R3"; end
            4'd4:  begin e.val = a | b;  e.req = "R3"; end
            4'd5:  begin e.val = a ^ b;  e.req = "R3"; end
            4'd6:  begin e.val = a + lit; arith = 1; e.req = "R4"; end
            4'd7:  begin e.val = a - lit; arith = 1; e.req = "R4"; end
            4'd8:  begin e.val = lit;    e.req = "R4"; end
            4'd9:  begin e.val = a + lit; e.ad = 1; e.req = "R5"; end
            4'd10: begin e.val = a + b;  e.ad = 1; e.req = "R5"; end
            default: e = bubble("R7");
        endcase
        if (e.v) e.z = arith && (e.val == 0);
        if (e.v && e.z) e.req = "R6";
        return e;
    endfunction

    task automatic compare(input exp_t e);
        n_tests++;
        if (out_valid !== e.v || out_value !== e.val || out_tag !== e.tag ||
            out_zero !== e.z || out_is_addr !== e.ad) begin
            n_fail++;
            $display("FAIL %s: got v=%0b val=%h tag=%0d z=%0b ad=%0b exp v=%0b val=%h tag=%0d z=%0b ad=%0b",
                     e.req, out_valid, out_value, out_tag, out_zero, out_is_addr,
                     e.v, e.val, e.tag, e.z, e.ad);
        end
    endtask

    // drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input logic v, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] lit,
                        input logic [3:0] tag, input logic fl);
        exp_t e;
        in_valid = v; in_op = op; in_a = a; in_b = b; in_lit = lit; in_tag = tag; flush = fl;
        @(posedge clk);
        if (fl) begin
            foreach (pipe[i]) pipe[i] = bubble("R8");
            e = bubble("R8");
        end else if (!v) begin
            e = bubble("R7");
        end else begin
            e = ref_calc(op, a, b, lit, tag);
        end
        pipe.push_back(e);
        if (pipe.size() > 2) void'(pipe.pop_front());
        @(negedge clk);
        if (pipe.size() == 2) compare(pipe[0]);
        else compare(bubble("R1"));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 4'd0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CYC * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang, exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; flush = 0; in_valid = 1; in_op = 4'd0; in_a = 32'hdead;
        in_b = 32'h1; in_lit = 0; in_tag = 4'd3;
        repeat (3) @(negedge clk);
        compare(bubble("R1"));               // R1 during reset with live inputs
        rst_n = 1;
        pipe.delete();
        idle(2);                              // R1 after release

        // R3 register forms, including wrap and R6 zero cases
        step(1, 4'd0, 32'd5, 32'd7, 0, 4'd1, 0);
        step(1, 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 4'd2, 0);
        step(1, 4'd1, 32'd3, 32'd3, 0, 4'd3, 0);
        step(1, 4'd1, 32'd2, 32'd5, 0, 4'd4, 0);
        step(1, 4'd2, 32'h0001_0000, 32'h0001_0000, 0, 4'd5, 0);
        step(1, 4'd2, -32'sd3, 32'd7, 0, 4'd6, 0);
        step(1, 4'd3, 32'hF0F0_1234, 32'h0F0F_FFFF, 0, 4'd7, 0);
        step(1, 4'd4, 32'hA000_0001, 32'h0500_0010, 0, 4'd8, 0);
        step(1, 4'd5, 32'h1234_5678, 32'h1234_5678, 0, 4'd9, 0);   // R6 xor zero, flag clear
        step(1, 4'd3, 32'hAAAA_AAAA, 32'h5555_5555, 0, 4'd10, 0);  // R6 and zero, flag clear
        // R4 literal forms and constant move
        step(1, 4'd6, 32'd10, -32'sd1, -32'sd1, 4'd11, 0);
        step(1, 4'd7, 32'd9, 32'd0, 32'd9, 4'd12, 0);
        step(1, 4'd8, 32'hFFFF_0000, 32'h1234, -32'sd42, 4'd13, 0);
        step(1, 4'd8, 32'd7, 32'd7, 32'd0, 4'd14, 0);              // R6 move of zero, flag clear
        // R5 address forms
        step(1, 4'd9, 32'd4000, 32'd99, 32'd12, 4'd15, 0);
        step(1, 4'd10, 32'd100, 32'd24, 32'd5, 4'd0, 0);
        step(1, 4'd9, 32'd8, 32'd0, -32'sd8, 4'd1, 0);             // R6 zero address, flag clear
        // R7 illegal opcodes and bubbles interleaved
        step(1, 4'd13, 32'd1, 32'd1, 0, 4'd2, 0);
        step(0, 4'd0, 32'd1, 32'd2, 0, 4'd3, 0);
        step(1, 4'd15, 32'd1, 32'd1, 0, 4'd4, 0);
        step(1, 4'd0, 32'd1, 32'd1, 0, 4'd5, 0);
        idle(2);
        // R8 flush with both stages full and an input waiting, then resume
        step(1, 4'd0, 32'd1, 32'd2, 0, 4'd6, 0);
        step(1, 4'd0, 32'd3, 32'd4, 0, 4'd7, 0);
        step(1, 4'd0, 32'd5, 32'd6, 0, 4'd8, 1);
        step(1, 4'd1, 32'd50, 32'd8, 0, 4'd9, 0);
        step(1, 4'd2, 32'd6, 32'd7, 0, 4'd10, 0);
        idle(2);

        // random mix: flushes, bubbles, illegal opcodes, zero-producing operands
        for (int k = 0; k < 600; k++) begin
            logic [31:0] ra, rb, rl;
            ra = $urandom;
            rb = ($urandom_range(0, 3) == 0) ? ra : $urandom;
            rl = ($urandom_range(0, 3) == 0) ? ra : $urandom;
            if ($urandom_range(0, 4) == 0) rb = 0;
            step($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)), ra, rb, rl,
                 4'($urandom_range(0, 15)), $urandom_range(0, 15) == 0);
        end
        idle(3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule